// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gate

This block sits between a host and a battery-backed static RAM. It conditions the memory's active-low chip-enable so that the RAM is write-protected whenever the supply is out of tolerance. An external comparator supplies an asynchronous power-good flag. The block synchronizes that flag and runs a four-state controller (normal, drain, protect, recover). From that controller it derives three outputs: the conditioned enable, an active-low system reset and a write-protect status flag.

When power-good drops, the enable is closed at once unless an access is already under way. In that case the access may finish, but only within a bounded window of clock cycles. After that window the enable is forced inactive. When power returns, the enable is held inactive for a fixed number of cycles regardless of the host, and the reset is held low for the same period. Both are released together.

Top module: `pfgate_top`

## Requirements
- R1: While the block is in normal operation (resetN high), memCeN equals hostCeN combinationally, with no added clock delay.
- R2: If pwrGoodAsync falls while hostCeN is high (idle), memCeN is high and wrProtect is high from the third rising clock edge onward. Any later hostCeN value, including low, has no effect on memCeN.
- R3: If hostCeN is low at the edge where the synchronized power-good is first seen low, the block enters drain. In drain, memCeN continues to follow the ongoing low access, and resetN and wrProtect are both low.
- R4: Drain lasts at most WP_CYCLES clock cycles. If hostCeN is still low after that, memCeN is forced high and wrProtect rises.
- R5: If hostCeN returns high during drain, memCeN goes high at once and the block moves to protect at the next edge. A new access that begins after that is never passed through.
- R6: resetN is low whenever the block is not in normal operation. During and right after reset (rstN low), memCeN=1, resetN=0 and wrProtect=1.
- R7: Once synchronized power-good is seen high in protect, the block stays in recovery for exactly RECOVER_CYCLES cycles, with memCeN high whatever hostCeN does. resetN rises RECOVER_CYCLES+3 edges after pwrGoodAsync rises, and memCeN is released on that same edge.
- R8: A loss of power-good during recovery returns the block to protect. The next return of power restarts the full recovery hold.
- R9: wrProtect is high in protect and recovery, and low in normal and drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrGoodAsync | input | 1 | Asynchronous supply-valid flag from an external comparator, 1 = valid |
| hostCeN | input | 1 | Host chip-enable, active low |
| memCeN | output | 1 | Conditioned chip-enable to the memory, active low |
| resetN | output | 1 | System reset, active low |
| wrProtect | output | 1 | High while the memory is write-protected |

## Verification
The pass-through path is driven with a table of host enable patterns in normal operation, including single-cycle pulses and long lows. This separates a true combinational follow from a registered or stuck output. Power is removed under four conditions, and each one pins down a different branch of the drop transition: with the host idle, with an access held past the timeout, with an access released early, and with a new access started after release. Power is restored twice: once cleanly, and once with a dropout partway through recovery. Counting the exact edge at which reset rises tells a correct hold apart from a counter that is off by one or fails to restart.

// File: rtl/pfgate_pkg.sv
package pfgate_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_PROTECT = 2'd2,
    ST_RECOVER = 2'd3
  } pfState_t;

  typedef struct packed {
    logic loadWp;
    logic decWp;
    logic loadRec;
    logic decRec;
    logic passEn;
    logic rstRelease;
    logic protFlag;
  } ctrlStrobe_t;

endpackage

// File: rtl/pfgate_sync.sv
module pfgate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
      end
    end else begin : gMulti
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/pfgate_ctrl.sv
module pfgate_ctrl
  import pfgate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pgSync,
  input  logic        hostCeN,
  input  logic        wpDone,
  input  logic        recDone,
  output ctrlStrobe_t strobe,
  output pfState_t    stateQ
);
  pfState_t stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_NORMAL: begin
        if (!pgSync) stateD = hostCeN ? ST_PROTECT : ST_DRAIN;
      end
      ST_DRAIN: begin
        if (hostCeN || wpDone) stateD = ST_PROTECT;
      end
      ST_PROTECT: begin
        if (pgSync) stateD = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (!pgSync)      stateD = ST_PROTECT;
        else if (recDone) stateD = ST_NORMAL;
      end
      default: stateD = ST_PROTECT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_PROTECT;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe            = '0;
    strobe.loadWp     = (stateQ == ST_NORMAL) && !pgSync && !hostCeN;
    strobe.decWp      = (stateQ == ST_DRAIN);
    strobe.loadRec    = (stateQ == ST_PROTECT) && pgSync;
    strobe.decRec     = (stateQ == ST_RECOVER);
    strobe.passEn     = (stateQ == ST_NORMAL) || (stateQ == ST_DRAIN);
    strobe.rstRelease = (stateQ == ST_NORMAL);
    strobe.protFlag   = (stateQ == ST_PROTECT) || (stateQ == ST_RECOVER);
  end
endmodule

// File: rtl/pfgate_dp.sv
module pfgate_dp
  import pfgate_pkg::*;
#(
  parameter int WP_CYCLES      = 8,
  parameter int RECOVER_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostCeN,
  input  ctrlStrobe_t strobe,
  output logic        wpDone,
  output logic        recDone,
  output logic        memCeN,
  output logic        resetN,
  output logic        wrProtect
);
  localparam int WP_W  = (WP_CYCLES > 1)      ? $clog2(WP_CYCLES)      : 1;
  localparam int REC_W = (RECOVER_CYCLES > 1) ? $clog2(RECOVER_CYCLES) : 1;
  localparam logic [WP_W-1:0]  WP_LOAD  = WP_W'(WP_CYCLES - 1);
  localparam logic [REC_W-1:0] REC_LOAD = REC_W'(RECOVER_CYCLES - 1);

  logic [WP_W-1:0]  wpCnt;
  logic [REC_W-1:0] recCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wpCnt <= '0;
    end else if (strobe.loadWp) begin
      wpCnt <= WP_LOAD;
    end else if (strobe.decWp && (wpCnt != '0)) begin
      wpCnt <= wpCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recCnt <= '0;
    end else if (strobe.loadRec) begin
      recCnt <= REC_LOAD;
    end else if (strobe.decRec && (recCnt != '0)) begin
      recCnt <= recCnt - 1'b1;
    end
  end

  assign wpDone    = (wpCnt == '0);
  assign recDone   = (recCnt == '0);
  assign memCeN    = hostCeN | ~strobe.passEn;
  assign resetN    = strobe.rstRelease;
  assign wrProtect = strobe.protFlag;
endmodule

// File: rtl/pfgate_top.sv
module pfgate_top
  import pfgate_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int WP_CYCLES      = 8,
  parameter int RECOVER_CYCLES = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwrGoodAsync,
  input  logic hostCeN,
  output logic memCeN,
  output logic resetN,
  output logic wrProtect
);
  logic        pgSync;
  logic        wpDone;
  logic        recDone;
  ctrlStrobe_t strobe;
  pfState_t    stateQ;

  pfgate_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pwrGoodAsync),
    .syncOut (pgSync)
  );

  pfgate_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .pgSync  (pgSync),
    .hostCeN (hostCeN),
    .wpDone  (wpDone),
    .recDone (recDone),
    .strobe  (strobe),
    .stateQ  (stateQ)
  );

  pfgate_dp #(
    .WP_CYCLES      (WP_CYCLES),
    .RECOVER_CYCLES (RECOVER_CYCLES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .hostCeN   (hostCeN),
    .strobe    (strobe),
    .wpDone    (wpDone),
    .recDone   (recDone),
    .memCeN    (memCeN),
    .resetN    (resetN),
    .wrProtect (wrProtect)
  );
endmodule

// File: rtl/pfgate_chk.sv
module pfgate_chk #(
  parameter int WP_CYCLES      = 8,
  parameter int RECOVER_CYCLES = 20
) (
  input logic clk,
  input logic rstN,
  input logic hostCeN,
  input logic memCeN,
  input logic resetN,
  input logic wrProtect
);
  logic        inDrain;
  int unsigned drainCnt;
  int unsigned protCnt;

  assign inDrain = !wrProtect && !resetN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drainCnt <= 0;
      protCnt  <= 0;
    end else begin
      drainCnt <= inDrain ? drainCnt + 1 : 0;
      if (!wrProtect)              protCnt <= 0;
      else if (protCnt < 32'hFFFF) protCnt <= protCnt + 1;
    end
  end

  AST_NORMAL_FOLLOWS_HOST: assert property (@(posedge clk) disable iff (!rstN)
    resetN |-> (memCeN == hostCeN)); // R1

  AST_PROTECT_GATES_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    wrProtect |-> memCeN); // R2

  AST_DRAIN_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    inDrain |-> (drainCnt < WP_CYCLES)); // R4

  AST_RELEASE_ENDS_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (inDrain && hostCeN) |=> wrProtect); // R5

  AST_RESET_NOT_WITH_PROTECT: assert property (@(posedge clk) disable iff (!rstN)
    wrProtect |-> !resetN); // R6

  AST_RESET_RISES_FROM_PROTECT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> $past(wrProtect)); // R7

  AST_RECOVER_HOLD_MET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> (protCnt >= RECOVER_CYCLES)); // R7
endmodule

bind pfgate_top pfgate_chk #(
  .WP_CYCLES      (WP_CYCLES),
  .RECOVER_CYCLES (RECOVER_CYCLES)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .hostCeN   (hostCeN),
  .memCeN    (memCeN),
  .resetN    (resetN),
  .wrProtect (wrProtect)
);

// File: tb/sim_pfgate_top.sv
`timescale 1ns/1ps
module sim_pfgate_top;
  localparam int WP  = 8;
  localparam int RC  = 20;
  localparam int NV  = 8;
  localparam logic [NV-1:0] HOST_VEC = 8'b0110_0100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrGoodAsync = 1'b0;
  logic hostCeN = 1'b1;
  logic memCeN, resetN, wrProtect;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pfgate_top #(.SYNC_STAGES(2), .WP_CYCLES(WP), .RECOVER_CYCLES(RC)) u0 (
    .clk(clk), .rstN(rstN), .pwrGoodAsync(pwrGoodAsync), .hostCeN(hostCeN),
    .memCeN(memCeN), .resetN(resetN), .wrProtect(wrProtect)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  initial begin
    tick(3);
    chk("R6", "memCeN in reset", memCeN, 1'b1);
    chk("R6", "resetN in reset", resetN, 1'b0);
    chk("R9", "wrProtect in reset", wrProtect, 1'b1);

    // R7: clean power-up, host held low to show it is ignored during hold
    rstN = 1'b1;
    pwrGoodAsync = 1'b1;
    hostCeN = 1'b0;
    tick(RC + 2);
    chk("R7", "resetN before hold ends", resetN, 1'b0);
    chk("R7", "memCeN during hold", memCeN, 1'b1);
    chk("R9", "wrProtect during hold", wrProtect, 1'b1);
    tick(1);
    chk("R7", "resetN after hold", resetN, 1'b1);
    chk("R7", "memCeN released", memCeN, 1'b0);
    chk("R9", "wrProtect in normal", wrProtect, 1'b0);

    // R1: table of host patterns in normal operation
    for (int i = 0; i < NV; i++) begin
      hostCeN = HOST_VEC[i];
      #1;
      chk("R1", "memCeN follows host", memCeN, HOST_VEC[i]);
      tick(1);
    end

    // R3/R4: access held past the timeout
    hostCeN = 1'b0;
    pwrGoodAsync = 1'b0;
    tick(2);
    chk("R3", "memCeN before detection", memCeN, 1'b0);
    tick(1);
    chk("R3", "memCeN in drain", memCeN, 1'b0);
    chk("R3", "resetN in drain", resetN, 1'b0);
    chk("R9", "wrProtect in drain", wrProtect, 1'b0);
    tick(WP - 1);
    chk("R4", "memCeN at last drain cycle", memCeN, 1'b0);
    tick(1);
    chk("R4", "memCeN after timeout", memCeN, 1'b1);
    chk("R4", "wrProtect after timeout", wrProtect, 1'b1);
    hostCeN = 1'b1;

    // R8: dropout during recovery restarts the hold
    pwrGoodAsync = 1'b1;
    tick(7);
    chk("R8", "still recovering", resetN, 1'b0);
    pwrGoodAsync = 1'b0;
    tick(3);
    chk("R8", "back to protect", wrProtect, 1'b1);
    pwrGoodAsync = 1'b1;
    tick(RC + 2);
    chk("R8", "resetN held for full restart", resetN, 1'b0);
    tick(1);
    chk("R8", "resetN after full restart", resetN, 1'b1);

    // R5: access released early, then a new access is blocked
    hostCeN = 1'b0;
    pwrGoodAsync = 1'b0;
    tick(3);
    chk("R5", "memCeN in drain", memCeN, 1'b0);
    tick(2);
    hostCeN = 1'b1;
    #1;
    chk("R5", "memCeN on release", memCeN, 1'b1);
    tick(1);
    chk("R5", "wrProtect after release", wrProtect, 1'b1);
    hostCeN = 1'b0;
    #1;
    chk("R5", "new access blocked", memCeN, 1'b1);
    tick(WP);
    chk("R5", "new access still blocked", memCeN, 1'b1);
    hostCeN = 1'b1;

    // R2: power loss while idle
    pwrGoodAsync = 1'b1;
    tick(RC + 3);
    chk("R7", "resetN after recovery", resetN, 1'b1);
    pwrGoodAsync = 1'b0;
    tick(3);
    chk("R2", "wrProtect after idle drop", wrProtect, 1'b1);
    chk("R2", "memCeN after idle drop", memCeN, 1'b1);
    hostCeN = 1'b0;
    #1;
    chk("R2", "host low ignored", memCeN, 1'b1);
    tick(4);
    chk("R2", "host low still ignored", memCeN, 1'b1);
    chk("R6", "resetN while power bad", resetN, 1'b0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule